// File: doc/BRIEF.md
# Instruction T-State Sequencer

This block paces a small 8-bit processor through the clock periods of each instruction. Every instruction opens with three fixed fetch periods: address out, program-counter increment, memory read. At the clock edge that closes the third one, the sequencer takes the decoded instruction class and, for conditional jumps, the condition-met flag. From these it fixes how many periods the instruction lasts and how many bytes it occupies. It then counts through the execute periods, marks the last one with a single-cycle end pulse, and starts the next instruction at T1.

A halt instruction runs its five periods and then freezes the sequencer until reset. A free-running cycle counter advances on every clock edge that is not halted. A program's elapsed time, one period per clock, can therefore be read directly and compared with hand-computed totals.

Top module: `tstate_seq`

## Requirements
- R1: After reset is released, tstate_o = 1, tstate_oh_o = 1, eoi_o = 0, nbytes_o = 0, halted_o = 0 and cycles_o = 0.
- R2: Every instruction runs through T1, T2 and T3 on consecutive clocks, whatever its class. nbytes_o is 0 during these three periods.
- R3: Class codes on iclass_i set the length and byte count. 0 is register/ALU/NOP (4 periods, 1 byte). 1 is immediate (7, 2). 2 is port in/out (10, 2). 3 is direct load/store (13, 3). 4 is call (18, 3). 5 is unconditional jump (10, 3). 7 is return (10, 1).
- R4: Class 6 is a conditional jump. It lasts 10 periods when cond_i is high at the end of T3 and 7 periods when it is low. It is 3 bytes either way.
- R5: iclass_i and cond_i are taken only at the clock edge that ends T3. Changes after that edge do not alter the current instruction, and cond_i has no effect on any class other than 6.
- R6: Unassigned class codes 9 to 15 behave as 4 periods and 1 byte.
- R7: eoi_o is high for exactly one clock, in the last period of the instruction. The following clock shows T1, except after a halt.
- R8: Class 8 (halt) lasts 5 periods with eoi_o in T5. After that, halted_o = 1, tstate_o = 0, tstate_oh_o = 0 and nbytes_o = 0, eoi_o stays low, and inputs are ignored until reset.
- R9: cycles_o increments on every clock edge at which halted_o is low and holds while halted. At the start of any T1 it equals the number of periods elapsed since reset.
- R10: tstate_oh_o has only bit k-1 set during period Tk.
- R11: nbytes_o shows the byte count of the current instruction from T4 through its last period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one T-state per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iclass_i | input | 4 | Decoded instruction class, taken at end of T3 |
| cond_i | input | 1 | Branch condition met, taken at end of T3 |
| tstate_o | output | 5 | Current T-state number, 0 when halted |
| tstate_oh_o | output | 18 | One-hot T-state, bit k-1 for Tk |
| eoi_o | output | 1 | End of instruction, high in the last T-state |
| nbytes_o | output | 2 | Instruction byte count, valid from T4 |
| halted_o | output | 1 | Sequencer frozen by halt |
| cycles_o | output | 32 | Running count of non-halted clocks |

## Verification
In the fifth period of a halt, the end pulse, the final cycle-counter increment and the entry into the frozen state all fall on the same clock edge. The halt test records cycles_o at the halt's T1. One clock after the end pulse, the counter must read exactly five more, tstate_o must be 0, and the counter must stay unchanged over the following idle clocks while the class input is toggled. A second overlap, the end pulse coinciding with the first execute period, is provoked by register-class instructions and judged on the following clock, which must be T1 again.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
  typedef enum logic [3:0] {
    CL_REG  = 4'd0,
    CL_IMM  = 4'd1,
    CL_IO   = 4'd2,
    CL_MEM  = 4'd3,
    CL_CALL = 4'd4,
    CL_JMP  = 4'd5,
    CL_JCC  = 4'd6,
    CL_RET  = 4'd7,
    CL_HLT  = 4'd8
  } iclass_e;

  localparam int unsigned FETCH_LAST = 3;
  localparam int unsigned LEN_REG    = 4;
  localparam int unsigned LEN_IMM    = 7;
  localparam int unsigned LEN_IO     = 10;
  localparam int unsigned LEN_MEM    = 13;
  localparam int unsigned LEN_CALL   = 18;
  localparam int unsigned LEN_JMP    = 10;
  localparam int unsigned LEN_JCC_T  = 10;
  localparam int unsigned LEN_JCC_N  = 7;
  localparam int unsigned LEN_RET    = 10;
  localparam int unsigned LEN_HLT    = 5;
endpackage

// File: rtl/tseq_len_lut.sv
module tseq_len_lut
  import tseq_pkg::*;
#(
  parameter int unsigned TW = 5
) (
  input  logic [3:0]    cls_i,
  input  logic          cond_i,
  output logic [TW-1:0] len_o,
  output logic [1:0]    nbytes_o,
  output logic          hlt_o
);
  always_comb begin
    hlt_o    = 1'b0;
    len_o    = TW'(LEN_REG);
    nbytes_o = 2'd1;
    case (cls_i)
      CL_IMM:  begin len_o = TW'(LEN_IMM);  nbytes_o = 2'd2; end
      CL_IO:   begin len_o = TW'(LEN_IO);   nbytes_o = 2'd2; end
      CL_MEM:  begin len_o = TW'(LEN_MEM);  nbytes_o = 2'd3; end
      CL_CALL: begin len_o = TW'(LEN_CALL); nbytes_o = 2'd3; end
      CL_JMP:  begin len_o = TW'(LEN_JMP);  nbytes_o = 2'd3; end
      CL_JCC:  begin
        len_o    = cond_i ? TW'(LEN_JCC_T) : TW'(LEN_JCC_N);
        nbytes_o = 2'd3;
      end
      CL_RET:  len_o = TW'(LEN_RET);
      CL_HLT:  begin len_o = TW'(LEN_HLT); hlt_o = 1'b1; end
      default: ; // register class and unassigned codes
    endcase
  end
endmodule

// File: rtl/tseq_step.sv
module tseq_step
  import tseq_pkg::*;
#(
  parameter int unsigned TW    = 5,
  parameter int unsigned MAX_T = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TW-1:0]    len_i,
  input  logic [1:0]       nbytes_i,
  input  logic             hlt_i,
  output logic [TW-1:0]    tstate_o,
  output logic [MAX_T-1:0] tstate_oh_o,
  output logic             eoi_o,
  output logic [1:0]       nbytes_o,
  output logic             halted_o
);
  localparam logic [TW-1:0] T_FIRST = TW'(1);
  localparam logic [TW-1:0] T_FLAST = TW'(FETCH_LAST);

  logic [TW-1:0] t_q, len_q;
  logic [1:0]    nb_q;
  logic          hlt_q, halted_q, exec_q;

  assign eoi_o = ~halted_q & exec_q & (t_q == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q      <= T_FIRST;
      len_q    <= '0;
      nb_q     <= '0;
      hlt_q    <= 1'b0;
      halted_q <= 1'b0;
      exec_q   <= 1'b0;
    end else if (!halted_q) begin
      if (t_q == T_FLAST) begin
        // length is fixed here, from class and condition of this edge
        len_q  <= len_i;
        nb_q   <= nbytes_i;
        hlt_q  <= hlt_i;
        exec_q <= 1'b1;
        t_q    <= t_q + T_FIRST;
      end else if (eoi_o) begin
        exec_q <= 1'b0;
        if (hlt_q) begin
          halted_q <= 1'b1;
          t_q      <= '0;
        end else begin
          t_q <= T_FIRST;
        end
      end else begin
        t_q <= t_q + T_FIRST;
      end
    end
  end

  for (genvar k = 0; k < MAX_T; k++) begin : g_oh
    assign tstate_oh_o[k] = ~halted_q & (t_q == TW'(k + 1));
  end

  assign tstate_o = t_q;
  assign nbytes_o = exec_q ? nb_q : 2'd0;
  assign halted_o = halted_q;
endmodule

// File: rtl/tseq_cycle_ctr.sv
module tseq_cycle_ctr #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (en_i) cnt_o <= cnt_o + CW'(1);
  end
endmodule

// File: rtl/tstate_seq.sv
module tstate_seq #(
  parameter int unsigned MAX_T = 18,
  parameter int unsigned CW    = 32,
  localparam int unsigned TW   = $clog2(MAX_T + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       iclass_i,
  input  logic             cond_i,
  output logic [TW-1:0]    tstate_o,
  output logic [MAX_T-1:0] tstate_oh_o,
  output logic             eoi_o,
  output logic [1:0]       nbytes_o,
  output logic             halted_o,
  output logic [CW-1:0]    cycles_o
);
  logic [TW-1:0] len;
  logic [1:0]    nb;
  logic          hlt;

  tseq_len_lut #(.TW(TW)) u_lut (
    .cls_i    (iclass_i),
    .cond_i   (cond_i),
    .len_o    (len),
    .nbytes_o (nb),
    .hlt_o    (hlt)
  );

  tseq_step #(.TW(TW), .MAX_T(MAX_T)) u_step (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .len_i       (len),
    .nbytes_i    (nb),
    .hlt_i       (hlt),
    .tstate_o    (tstate_o),
    .tstate_oh_o (tstate_oh_o),
    .eoi_o       (eoi_o),
    .nbytes_o    (nbytes_o),
    .halted_o    (halted_o)
  );

  tseq_cycle_ctr #(.CW(CW)) u_cyc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (~halted_o),
    .cnt_o  (cycles_o)
  );
endmodule

// File: rtl/tstate_seq_chk.sv
module tstate_seq_chk #(
  parameter int unsigned MAX_T = 18,
  parameter int unsigned CW    = 32,
  parameter int unsigned TW    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       iclass_i,
  input logic             cond_i,
  input logic [TW-1:0]    tstate_o,
  input logic [MAX_T-1:0] tstate_oh_o,
  input logic             eoi_o,
  input logic [1:0]       nbytes_o,
  input logic             halted_o,
  input logic [CW-1:0]    cycles_o
);
  logic jcc_q, cnd_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      jcc_q <= 1'b0;
      cnd_q <= 1'b0;
    end else if (tstate_o == TW'(3) && !halted_o) begin
      jcc_q <= (iclass_i == 4'd6);
      cnd_q <= cond_i;
    end
  end

  p_fetch_t1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tstate_o == TW'(1)) |=> (tstate_o == TW'(2)));
  p_fetch_t2_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tstate_o == TW'(2)) |=> (tstate_o == TW'(3)));
  p_fetch_nb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tstate_o != '0 && tstate_o <= TW'(3)) |-> (nbytes_o == 2'd0));
  p_eoi_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |-> (tstate_o == TW'(4) || tstate_o == TW'(5) || tstate_o == TW'(7) ||
               tstate_o == TW'(10) || tstate_o == TW'(13) || tstate_o == TW'(18)));
  p_jcc_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_o && jcc_q) |-> (tstate_o == (cnd_q ? TW'(10) : TW'(7))));
  p_eoi_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |=> !eoi_o);
  p_eoi_next_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |=> (tstate_o == TW'(1) || halted_o));
  p_halt_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && tstate_o == '0 && !eoi_o && nbytes_o == 2'd0));
  p_cyc_inc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halted_o |=> (cycles_o == $past(cycles_o) + CW'(1)));
  p_cyc_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(cycles_o));
  p_oh_one_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halted_o |-> ($countones(tstate_oh_o) == 1));
  p_oh_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (tstate_oh_o == '0));
  p_nb_exec_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_o && jcc_q) |-> (nbytes_o == 2'd3));
endmodule

bind tstate_seq tstate_seq_chk #(.MAX_T(MAX_T), .CW(CW), .TW(TW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iclass_i    (iclass_i),
  .cond_i      (cond_i),
  .tstate_o    (tstate_o),
  .tstate_oh_o (tstate_oh_o),
  .eoi_o       (eoi_o),
  .nbytes_o    (nbytes_o),
  .halted_o    (halted_o),
  .cycles_o    (cycles_o)
);

// File: tb/tstate_seq_test.sv
module tstate_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  iclass_i = 4'd0;
  logic        cond_i = 1'b0;
  logic [4:0]  tstate_o;
  logic [17:0] tstate_oh_o;
  logic        eoi_o;
  logic [1:0]  nbytes_o;
  logic        halted_o;
  logic [31:0] cycles_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  tstate_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .iclass_i(iclass_i), .cond_i(cond_i),
    .tstate_o(tstate_o), .tstate_oh_o(tstate_oh_o), .eoi_o(eoi_o),
    .nbytes_o(nbytes_o), .halted_o(halted_o), .cycles_o(cycles_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // call at a negedge in T1; leaves at the negedge after the end pulse
  task automatic run_instr(input logic [3:0] cls, input logic cnd,
                           input logic [3:0] cls_late, input logic cnd_late,
                           input int exp_len, input int exp_nb, input string req);
    int n = 1;
    int eois = 0;
    logic [1:0] nb = 2'd0;
    bit fetch_ok = 1'b1;
    bit oh_ok = 1'b1;
    iclass_i = cls;
    cond_i   = cnd;
    chk(tstate_o == 5'd1, "R2 start T1", tstate_o, 1);
    while (!eoi_o && n < 40) begin
      @(negedge clk_i);
      n++;
      if (tstate_o != 5'(n)) fetch_ok = 1'b0;
      if (n <= 3 && nbytes_o != 2'd0) fetch_ok = 1'b0;
      if (tstate_oh_o != (18'd1 << (n - 1))) oh_ok = 1'b0;
      if (n == 4) begin
        nb = nbytes_o;
        iclass_i = cls_late;
        cond_i   = cnd_late;
      end
    end
    if (eoi_o) eois++;
    chk(n == exp_len, {req, " length"}, n, exp_len);
    chk(nb == 2'(exp_nb) && nbytes_o == 2'(exp_nb), {"R11 bytes ", req}, nb, exp_nb);
    chk(fetch_ok, "R2 ordered T-states", 0, 1);
    chk(oh_ok, "R10 one-hot", 0, 1);
    @(negedge clk_i);
    chk(!eoi_o, "R7 pulse width", eoi_o, 0);
    if (cls == 4'd8) chk(halted_o && tstate_o == 5'd0, "R8 frozen", tstate_o, 0);
    else chk(tstate_o == 5'd1, "R7 next T1", tstate_o, 1);
  endtask

  task automatic t_reset;
    chk(tstate_o == 5'd1 && tstate_oh_o == 18'd1, "R1 tstate", tstate_o, 1);
    chk(!eoi_o && nbytes_o == 2'd0 && !halted_o, "R1 flags", {eoi_o, nbytes_o, halted_o}, 0);
    chk(cycles_o == 32'd0, "R1 cycles", cycles_o, 0);
  endtask

  task automatic t_classes;
    run_instr(4'd0, 1'b0, 4'd0, 1'b0, 4, 1, "R3 reg");
    run_instr(4'd1, 1'b0, 4'd1, 1'b0, 7, 2, "R3 imm");
    run_instr(4'd2, 1'b0, 4'd2, 1'b0, 10, 2, "R3 io");
    run_instr(4'd3, 1'b0, 4'd3, 1'b0, 13, 3, "R3 mem");
    run_instr(4'd4, 1'b0, 4'd4, 1'b0, 18, 3, "R3 call");
    run_instr(4'd5, 1'b0, 4'd5, 1'b0, 10, 3, "R3 jmp");
    run_instr(4'd7, 1'b0, 4'd7, 1'b0, 10, 1, "R3 ret");
  endtask

  task automatic t_jcc;
    run_instr(4'd6, 1'b1, 4'd6, 1'b1, 10, 3, "R4 taken");
    run_instr(4'd6, 1'b0, 4'd6, 1'b0, 7, 3, "R4 not taken");
  endtask

  task automatic t_late;
    run_instr(4'd6, 1'b1, 4'd6, 1'b0, 10, 3, "R5 late cond low");
    run_instr(4'd6, 1'b0, 4'd6, 1'b1, 7, 3, "R5 late cond high");
    run_instr(4'd0, 1'b1, 4'd8, 1'b1, 4, 1, "R5 late class");
    run_instr(4'd5, 1'b0, 4'd5, 1'b1, 10, 3, "R5 cond ignored jmp");
    run_instr(4'd0, 1'b1, 4'd0, 1'b0, 4, 1, "R5 cond ignored reg");
  endtask

  task automatic t_undef;
    for (int c = 9; c < 16; c++) run_instr(4'(c), 1'b1, 4'(c), 1'b1, 4, 1, "R6 unassigned");
  endtask

  // delay loop: MVI C; 70 x (DCR C; JNZ); NOP; RET -> 998 periods
  task automatic t_loop;
    logic [31:0] c0 = cycles_o;
    run_instr(4'd1, 1'b0, 4'd1, 1'b0, 7, 2, "R9 loop mvi");
    for (int i = 70; i > 0; i--) begin
      run_instr(4'd0, 1'b0, 4'd0, 1'b0, 4, 1, "R9 loop dcr");
      run_instr(4'd6, i > 1, 4'd6, i > 1, (i > 1) ? 10 : 7, 3, "R9 loop jnz");
    end
    run_instr(4'd0, 1'b0, 4'd0, 1'b0, 4, 1, "R9 loop nop");
    run_instr(4'd7, 1'b0, 4'd7, 1'b0, 10, 1, "R9 loop ret");
    chk(cycles_o - c0 == 32'd998, "R9 loop total", cycles_o - c0, 998);
  endtask

  task automatic t_halt;
    logic [31:0] c0 = cycles_o;
    bit quiet = 1'b1;
    run_instr(4'd8, 1'b0, 4'd0, 1'b1, 5, 1, "R8 halt");
    chk(cycles_o == c0 + 32'd5, "R9 halt cycles", cycles_o - c0, 5);
    for (int i = 0; i < 12; i++) begin
      iclass_i = 4'(i);
      cond_i = i[0];
      @(negedge clk_i);
      if (eoi_o || !halted_o || tstate_o != 5'd0 || tstate_oh_o != '0 || nbytes_o != 2'd0) quiet = 1'b0;
    end
    chk(quiet, "R8 inputs ignored", 0, 1);
    chk(cycles_o == c0 + 32'd5, "R9 frozen count", cycles_o - c0, 5);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk(!halted_o && tstate_o == 5'd1 && cycles_o == 32'd0, "R8 reset release", tstate_o, 1);
    iclass_i = 4'd0;
    run_instr(4'd0, 1'b0, 4'd0, 1'b0, 4, 1, "R8 after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_classes();
    t_jcc();
    t_late();
    t_undef();
    t_loop();
    t_halt();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule